// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader

This block sits on the transmit side of a spread-spectrum radio baseband. It takes a serial stream of data bits through a valid/ready handshake and turns each data symbol into a run of pseudo-noise chips. It emits one chip for every pulse of a chip-enable input, so the chip rate is set by whoever drives that strobe. The chips are taken from a 64-bit code word supplied on a port.

A 3-bit mode word selects how the code is used. The whole 64-bit code can spread each bit. Half of the code (32 chips) can spread each bit, with a select input choosing the upper or lower half. In the paired mode, each 32-chip symbol carries two bits: the first bit picks the half and the second bit sets the polarity. Mode words that do not name a legal combination are flagged, and the block then sends idle chips. When data runs dry at a symbol boundary, the block reports an underrun and sends idle chips until enough bits are buffered.

Top module: `dsss_spreader`

## Requirements
- R1: With mode word 000, each data bit spans 64 chips, and chip k of the symbol (k = 0..63) uses code bit 63-k, so the most significant code bit is sent first.
- R2: In the single-bit modes, each chip equals the code bit XOR the inverted data bit: a 1 sends the code as it is and a 0 sends it inverted.
- R3: With mode word 100, each data bit spans 32 chips. `half_hi`=1 uses code bits [63:32] and `half_hi`=0 uses bits [31:0], most significant first within the half.
- R4: Mode bit 0 (the oversampling hint) has no effect on the chips: mode 101 produces the same chips as mode 100.
- R5: With mode word 110, each 32-chip symbol takes two bits. The first bit accepted selects the half (1 = bits [63:32], 0 = bits [31:0]), and the second bit sets the polarity as in R2.
- R6: Mode words 001, 010, 011 and 111 are illegal. While one is applied, `mode_err` reads 1 from the next cycle on, each chip slot at a symbol boundary is idle (`chip_idle`=1, `chip_out`=0), no buffered bit is consumed, and `underrun` stays 0.
- R7: When a symbol boundary is reached with fewer buffered bits than the mode needs (1, or 2 in mode 110), that chip slot is idle with `underrun`=1. The next symbol starts at the first chip slot that finds enough data.
- R8: Each cycle with `chip_en`=1 produces exactly one chip, shown with `chip_stb`=1 on the following cycle. A cycle without `chip_en` gives `chip_stb`=0 and does not advance the sequence.
- R9: A bit is accepted in a cycle with `bit_valid`=1 and `bit_ready`=1. Up to two bits are held, and `bit_ready` is 0 while both places are occupied. Bits are removed only at symbol starts.
- R10: After reset, `chip_out`, `chip_stb`, `chip_idle`, `underrun` and `mode_err` are 0 and `bit_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip-rate strobe; one chip per high cycle |
| mode_cfg | input | 3 | Mode word: bit 2 half width, bit 1 paired bits, bit 0 oversampling hint |
| half_hi | input | 1 | Half select for mode 100/101 |
| pn_code | input | 64 | Spreading code word |
| bit_valid | input | 1 | Data bit offered |
| bit_data | input | 1 | Data bit value |
| bit_ready | output | 1 | Buffer can take a bit |
| chip_out | output | 1 | Current chip |
| chip_stb | output | 1 | Chip slot strobe, one cycle after `chip_en` |
| chip_idle | output | 1 | Current slot carries no symbol |
| underrun | output | 1 | Current slot idle for lack of data |
| mode_err | output | 1 | Applied mode word is illegal |

## Verification
The full-length mode is driven with a 1 followed by a 0, which separates the true code from its inverse and shows the chip order. The half-length mode is run with both half selects and with the oversampling hint set and clear, which separates the two halves and shows the hint has no effect. All four bit pairs are sent in paired mode, and each pair maps to a distinct half and polarity. Each illegal word is tried with a full buffer, then followed by a legal run that must start from the untouched bits. Sparse chip strobes, an empty buffer and a stalled feeder cover the timing, underrun and handshake cases.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

  typedef enum logic [1:0] {
    SF_LONG  = 2'd0,
    SF_SHORT = 2'd1,
    SF_PAIR  = 2'd2,
    SF_BAD   = 2'd3
  } spread_t;

  // bit 2: half-width code, bit 1: paired bits, bit 0: oversampling hint
  function automatic spread_t decode_mode(input logic [2:0] m);
    case (m)
      3'b000:         return SF_LONG;
      3'b100, 3'b101: return SF_SHORT;
      3'b110:         return SF_PAIR;
      default:        return SF_BAD;
    endcase
  endfunction

  function automatic logic [1:0] bits_needed(input spread_t k);
    case (k)
      SF_PAIR: return 2'd2;
      SF_BAD:  return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/dsss_bit_fifo.sv
module dsss_bit_fifo #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  input  logic [1:0]       pop_n,
  output logic [1:0]       head,
  output logic [CNT_W-1:0] level
);

  logic [DEPTH-1:0] q, nq;
  logic [CNT_W-1:0] count, after_pop, ncount;
  logic             push;

  assign in_ready = (int'(count) < DEPTH);
  assign push     = in_valid && in_ready;
  assign head     = q[1:0];
  assign level    = count;

  always_comb begin
    nq        = q >> pop_n;
    after_pop = count - CNT_W'(pop_n);
    for (int i = 0; i < DEPTH; i++) begin
      if (push && after_pop == CNT_W'(i)) nq[i] = in_bit;
    end
    ncount = after_pop + CNT_W'(push);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      count <= '0;
    end else begin
      q     <= nq;
      count <= ncount;
    end
  end

  // R9: occupancy never exceeds the number of places
  a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);

  // R7: the sequencer never takes more bits than are held
  a_r7_pop_covered: assert property (@(posedge clk) disable iff (rst)
    int'(pop_n) <= int'(count));

endmodule

// File: rtl/dsss_symbol_former.sv
module dsss_symbol_former
  import dsss_pkg::*;
#(
  parameter int CODE_W = 64,
  localparam int HALF  = CODE_W / 2,
  localparam int POS_W = $clog2(CODE_W)
) (
  input  logic [CODE_W-1:0] code,
  input  spread_t           kind,
  input  logic              half_hi,
  input  logic              b0,
  input  logic              b1,
  output logic [CODE_W-1:0] word,
  output logic [POS_W-1:0]  last_idx
);

  logic [HALF-1:0] upper, lower, pick;

  assign upper = code[CODE_W-1:HALF];
  assign lower = code[HALF-1:0];

  always_comb begin
    word     = '0;
    last_idx = '0;
    pick     = lower;
    case (kind)
      SF_LONG: begin
        word     = code ^ {CODE_W{~b0}};
        last_idx = POS_W'(CODE_W - 1);
      end
      SF_SHORT: begin
        pick     = half_hi ? upper : lower;
        word     = {pick ^ {HALF{~b0}}, {HALF{1'b0}}};
        last_idx = POS_W'(HALF - 1);
      end
      SF_PAIR: begin
        pick     = b0 ? upper : lower;
        word     = {pick ^ {HALF{~b1}}, {HALF{1'b0}}};
        last_idx = POS_W'(HALF - 1);
      end
      default: begin
        word     = '0;
        last_idx = '0;
      end
    endcase
  end

endmodule

// File: rtl/dsss_chip_seq.sv
module dsss_chip_seq
  import dsss_pkg::*;
#(
  parameter int CODE_W = 64,
  parameter int CNT_W  = 2,
  localparam int POS_W = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  spread_t           kind,
  input  logic [CNT_W-1:0]  level,
  input  logic [CODE_W-1:0] sym_word,
  input  logic [POS_W-1:0]  sym_last,
  output logic [1:0]        pop_n,
  output logic              chip_out,
  output logic              chip_stb,
  output logic              chip_idle,
  output logic              underrun,
  output logic              mode_err
);

  logic [POS_W-1:0]  pos, last_q;
  logic [CODE_W-1:0] sr;
  logic              boundary, start_ok;
  logic [1:0]        need;

  assign boundary = (pos == '0);
  assign need     = bits_needed(kind);
  assign start_ok = chip_en && boundary && (kind != SF_BAD) && (int'(level) >= int'(need));
  assign pop_n    = start_ok ? need : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      last_q    <= '0;
      sr        <= '0;
      chip_out  <= 1'b0;
      chip_stb  <= 1'b0;
      chip_idle <= 1'b0;
      underrun  <= 1'b0;
      mode_err  <= 1'b0;
    end else begin
      chip_stb <= chip_en;
      mode_err <= (kind == SF_BAD);
      if (chip_en) begin
        if (!boundary) begin
          chip_out  <= sr[CODE_W-1];
          sr        <= sr << 1;
          chip_idle <= 1'b0;
          underrun  <= 1'b0;
          pos       <= (pos == last_q) ? '0 : pos + POS_W'(1);
        end else if (start_ok) begin
          chip_out  <= sym_word[CODE_W-1];
          sr        <= sym_word << 1;
          last_q    <= sym_last;
          chip_idle <= 1'b0;
          underrun  <= 1'b0;
          pos       <= POS_W'(1);
        end else begin
          chip_out  <= 1'b0;
          chip_idle <= 1'b1;
          underrun  <= (kind != SF_BAD);
        end
      end
    end
  end

  // R6: an illegal mode at a boundary yields an idle slot without underrun
  a_r6_bad_mode_idle: assert property (@(posedge clk) disable iff (rst)
    (chip_en && boundary && kind == SF_BAD) |=> (chip_idle && !chip_out && !underrun));

  // R7: an underrun slot is always an idle slot carrying 0
  a_r7_underrun_idle: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (chip_idle && !chip_out));

  // R8: without a strobe the position holds and no chip is shown next cycle
  a_r8_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> ($stable(pos) && !chip_stb));

  // R1: the position inside a symbol never passes the symbol's last chip
  a_r1_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |-> (pos <= last_q));

endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import dsss_pkg::*;
#(
  parameter int CODE_W     = 64,
  parameter int FIFO_DEPTH = 2,
  localparam int POS_W     = $clog2(CODE_W),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic [2:0]        mode_cfg,
  input  logic              half_hi,
  input  logic [CODE_W-1:0] pn_code,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              chip_out,
  output logic              chip_stb,
  output logic              chip_idle,
  output logic              underrun,
  output logic              mode_err
);

  spread_t           kind;
  logic [1:0]        head, pop_n;
  logic [CNT_W-1:0]  level;
  logic [CODE_W-1:0] sym_word;
  logic [POS_W-1:0]  sym_last;

  assign kind = decode_mode(mode_cfg);

  dsss_bit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .in_valid (bit_valid),
    .in_bit   (bit_data),
    .in_ready (bit_ready),
    .pop_n    (pop_n),
    .head     (head),
    .level    (level)
  );

  dsss_symbol_former #(.CODE_W(CODE_W)) u_former (
    .code     (pn_code),
    .kind     (kind),
    .half_hi  (half_hi),
    .b0       (head[0]),
    .b1       (head[1]),
    .word     (sym_word),
    .last_idx (sym_last)
  );

  dsss_chip_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .kind      (kind),
    .level     (level),
    .sym_word  (sym_word),
    .sym_last  (sym_last),
    .pop_n     (pop_n),
    .chip_out  (chip_out),
    .chip_stb  (chip_stb),
    .chip_idle (chip_idle),
    .underrun  (underrun),
    .mode_err  (mode_err)
  );

endmodule

// File: tb/dsss_spreader_test.sv
module dsss_spreader_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CODE = 64'hD3A5_0F6C_81E7_2B49;

  logic clk = 1'b0, rst = 1'b1, chip_en = 1'b0, half_hi = 1'b0;
  logic [2:0] mode_cfg = 3'b000;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic bit_ready, chip_out, chip_stb, chip_idle, underrun, mode_err;

  int n_checks = 0, n_fail = 0;
  logic bits_q [0:15];
  int nbits = 0, bidx = 0;
  logic exp_c [0:511];
  int nexp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsss_spreader uut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .mode_cfg(mode_cfg),
    .half_hi(half_hi), .pn_code(CODE), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .chip_out(chip_out),
    .chip_stb(chip_stb), .chip_idle(chip_idle), .underrun(underrun),
    .mode_err(mode_err)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic hs);
    @(negedge clk);
    rst = 1'b1; chip_en = 1'b0; bit_valid = 1'b0;
    mode_cfg = m; half_hi = hs;
    bidx = 0; nbits = 0; nexp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one clock: drive at negedge, account handshake at posedge, return at negedge
  task automatic step(input logic ce);
    logic rdy;
    chip_en   = ce;
    bit_valid = (bidx < nbits);
    bit_data  = (bidx < nbits) ? bits_q[bidx] : 1'b0;
    rdy       = bit_ready;
    @(posedge clk);
    if (bit_valid && rdy) bidx++;
    @(negedge clk);
    chip_en = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic preload();
    while (bidx < nbits && bidx < 2) step(1'b0);
  endtask

  task automatic exp_sym(input int base, input int len, input logic pol);
    for (int k = 0; k < len; k++) begin
      exp_c[nexp] = CODE[base + len - 1 - k] ^ ~pol;
      nexp++;
    end
  endtask

  task automatic run_chips(input string tag);
    for (int k = 0; k < nexp; k++) begin
      step(1'b1);
      check(chip_stb === 1'b1 && chip_idle === 1'b0 && chip_out === exp_c[k],
            tag, int'(chip_out), int'(exp_c[k]));
    end
  endtask

  task automatic t_reset();
    do_reset(3'b000, 1'b0);
    check(chip_stb === 0 && chip_out === 0 && chip_idle === 0, "R10 chip outputs", int'(chip_stb), 0);
    check(underrun === 0 && mode_err === 0, "R10 flags", int'(underrun), 0);
    check(bit_ready === 1, "R10 ready", int'(bit_ready), 1);
  endtask

  task automatic t_long();
    do_reset(3'b000, 1'b0);
    bits_q[0] = 1; bits_q[1] = 0; nbits = 2;
    exp_sym(0, 64, 1'b1); exp_sym(0, 64, 1'b0);
    preload();
    run_chips("R1/R2 long code");
  endtask

  task automatic t_short();
    do_reset(3'b100, 1'b0);
    bits_q[0] = 1; bits_q[1] = 0; bits_q[2] = 1; nbits = 3;
    exp_sym(0, 32, 1'b1); exp_sym(0, 32, 1'b0); exp_sym(0, 32, 1'b1);
    preload();
    run_chips("R3 lower half");
    do_reset(3'b101, 1'b1);
    bits_q[0] = 0; bits_q[1] = 1; nbits = 2;
    exp_sym(32, 32, 1'b0); exp_sym(32, 32, 1'b1);
    preload();
    run_chips("R4 hint ignored, R3 upper half");
  endtask

  task automatic t_pair();
    do_reset(3'b110, 1'b0);
    bits_q[0] = 1; bits_q[1] = 1; bits_q[2] = 0; bits_q[3] = 0;
    bits_q[4] = 1; bits_q[5] = 0; bits_q[6] = 0; bits_q[7] = 1; nbits = 8;
    exp_sym(32, 32, 1'b1); exp_sym(0, 32, 1'b0);
    exp_sym(32, 32, 1'b0); exp_sym(0, 32, 1'b1);
    preload();
    run_chips("R5 paired bits");
  endtask

  task automatic t_bad();
    logic [2:0] bad [0:3];
    bad[0] = 3'b001; bad[1] = 3'b010; bad[2] = 3'b011; bad[3] = 3'b111;
    do_reset(3'b000, 1'b0);
    bits_q[0] = 1; bits_q[1] = 0; nbits = 2;
    preload();
    for (int i = 0; i < 4; i++) begin
      mode_cfg = bad[i];
      step(1'b0);
      for (int j = 0; j < 3; j++) begin
        step(1'b1);
        check(mode_err === 1, "R6 error flag", int'(mode_err), 1);
        check(chip_idle === 1 && chip_out === 0 && underrun === 0, "R6 idle slot", int'(chip_idle), 1);
        check(bit_ready === 0, "R6 bits kept", int'(bit_ready), 0);
      end
    end
    mode_cfg = 3'b000;
    step(1'b0);
    check(mode_err === 0, "R6 flag clears", int'(mode_err), 0);
    exp_sym(0, 64, 1'b1); exp_sym(0, 64, 1'b0);
    run_chips("R6 untouched bits used");
  endtask

  task automatic t_underrun();
    do_reset(3'b110, 1'b0);
    for (int j = 0; j < 3; j++) begin
      step(1'b1);
      check(underrun === 1 && chip_idle === 1 && chip_out === 0, "R7 empty", int'(underrun), 1);
    end
    bits_q[0] = 0; nbits = 1;
    preload();
    step(1'b1);
    check(underrun === 1 && chip_idle === 1, "R7 one bit short in pair mode", int'(underrun), 1);
    bits_q[1] = 1; nbits = 2;
    preload();
    exp_sym(0, 32, 1'b1);
    run_chips("R7 resumes");
    check(underrun === 0, "R7 flag low with data", int'(underrun), 0);
  endtask

  task automatic t_sparse();
    do_reset(3'b100, 1'b0);
    bits_q[0] = 0; nbits = 1;
    exp_sym(0, 32, 1'b0);
    preload();
    for (int k = 0; k < nexp; k++) begin
      step(1'b1);
      check(chip_stb === 1 && chip_out === exp_c[k], "R8 strobed chip", int'(chip_out), int'(exp_c[k]));
      step(1'b0);
      check(chip_stb === 0, "R8 no strobe", int'(chip_stb), 0);
      step(1'b0);
    end
  endtask

  task automatic t_ready();
    do_reset(3'b000, 1'b0);
    bits_q[0] = 1; bits_q[1] = 1; bits_q[2] = 0; nbits = 3;
    step(1'b0);
    check(bit_ready === 1 && bidx == 1, "R9 first accepted", bidx, 1);
    step(1'b0);
    check(bit_ready === 0 && bidx == 2, "R9 full", int'(bit_ready), 0);
    repeat (4) step(1'b0);
    check(bidx == 2 && bit_ready === 0, "R9 stalled", bidx, 2);
    step(1'b1);
    check(bit_ready === 1, "R9 room after symbol start", int'(bit_ready), 1);
  endtask

  initial begin
    t_reset();
    t_long();
    t_short();
    t_pair();
    t_bad();
    t_underrun();
    t_sparse();
    t_ready();
    report();
  end

endmodule